// File: doc/BRIEF.md
# Protected Page Map Entry Checker

This block decides whether one metadata entry, taken from the map that describes protected memory pages, is acceptable for a particular use. It is used during the admission steps before a thread enters an enclave. The caller supplies the entry's fields, the linear address being touched, the kind of page it expects, the enclave it expects to own the page, and whether the access must be readable and writable. Walking page tables and fetching the entry are the caller's job. Raising the resulting exception is also left to the caller.

A single-cycle `req_valid` pulse starts a check. One clock later the block pulses `done` and presents either `pass` or `fault`. On a fault it also presents the faulting linear address. Every reason for rejection leads to the same page-fault outcome. The block rejects an entry that is not valid, is blocked, or is in transition (pending or modified). It also rejects an entry whose recorded address differs from the access, whose page type is wrong, whose owner is another enclave, or whose permissions are too weak for the access.

Top module: `pmc_entry_checker`

## Requirements
- R1: While reset is applied, and after it is released until the first check, `done`, `pass` and `fault` are 0 and `fault_addr` is all zeros.
- R2: A `req_valid` pulse sampled at one rising edge makes `done` equal 1 for exactly the following cycle. `done` is never 1 in a cycle that does not follow a request.
- R3: An entry whose `ent_valid` is 0 produces `fault` = 1, with `fault_addr` equal to `acc_addr`.
- R4: An entry with `ent_blocked` = 1 produces a fault.
- R5: An entry with `ent_pending` = 1 or `ent_modified` = 1 produces a fault.
- R6: A fault is produced when `ent_lin_addr` differs from `acc_addr` in any bit.
- R7: Page types use 3-bit codes: 1 means thread-control and 2 means regular. A fault is produced when `ent_type` differs from `exp_type`. A fault is also produced when `exp_type` is any code other than 1 or 2, even if the two fields are equal.
- R8: When `exp_type` is 2 (regular), a fault is produced if `ent_owner` differs from `exp_owner`. When `exp_type` is 1, the owner fields have no effect on the result.
- R9: When `need_rw` is 1, a fault is produced unless both `ent_read` and `ent_write` are 1. When `need_rw` is 0, the permission bits have no effect.
- R10: In the cycle where `done` is 1, exactly one of `pass` and `fault` is 1. `pass` is 1 exactly when none of R3 to R9 applies. A passing check clears `fault_addr` to zero.
- R11: Between checks, `pass`, `fault` and `fault_addr` keep their last values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle pulse that starts a check |
| ent_valid | input | 1 | Entry valid bit |
| ent_blocked | input | 1 | Entry blocked bit |
| ent_pending | input | 1 | Entry pending (in transition) bit |
| ent_modified | input | 1 | Entry modified (in transition) bit |
| ent_lin_addr | input | ADDR_W | Linear address recorded in the entry |
| ent_type | input | 3 | Page type code recorded in the entry |
| ent_owner | input | OWNER_W | Owning-enclave identifier recorded in the entry |
| ent_read | input | 1 | Entry read permission |
| ent_write | input | 1 | Entry write permission |
| acc_addr | input | ADDR_W | Linear address being accessed |
| exp_type | input | 3 | Expected page type code |
| exp_owner | input | OWNER_W | Expected owning-enclave identifier |
| need_rw | input | 1 | Access requires read and write permission |
| done | output | 1 | One-cycle pulse that marks a result |
| pass | output | 1 | Last check accepted the entry |
| fault | output | 1 | Last check raised a page fault |
| fault_addr | output | ADDR_W | Faulting linear address of the last check |

## Verification
The hardest case to reach from the ports is a single fault cause acting alone. Another check is then blocked only by that one cause. One example is an owner mismatch on a regular page that is otherwise perfect. Another is equal but unsupported type codes. To reach these, the bench sweeps the full product of all six entry flag bits, address match, all 8×8 type-code pairs, owner match and the `need_rw` flag. This gives 32768 vectors, so every isolated cause and every combination of causes appears. After each vector the bench holds `req_valid` low and scrambles all inputs, then confirms that the held result does not move.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned PTYPE_W = 3;
  typedef logic [PTYPE_W-1:0] ptype_t;
  localparam ptype_t PTYPE_THREAD  = 3'd1;
  localparam ptype_t PTYPE_REGULAR = 3'd2;

  typedef struct packed {
    logic valid;
    logic blocked;
    logic pending;
    logic modified;
    logic rd;
    logic wr;
  } ent_flags_t;
endpackage

// File: rtl/pmc_state_chk.sv
module pmc_state_chk
  import pmc_pkg::*;
(
  input  ent_flags_t flags,
  output logic       state_ok
);
  logic live_ok;
  logic settled_ok;

  always_comb begin
    live_ok    = flags.valid & ~flags.blocked;
    settled_ok = ~(flags.pending | flags.modified);
    state_ok   = live_ok & settled_ok;
  end
endmodule

// File: rtl/pmc_ident_chk.sv
module pmc_ident_chk
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 48,
  parameter int unsigned OWNER_W      = 16,
  parameter bit          OWNER_CHK_EN = 1'b1
) (
  input  logic [ADDR_W-1:0]  ent_lin_addr,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  ptype_t             ent_type,
  input  ptype_t             exp_type,
  input  logic [OWNER_W-1:0] ent_owner,
  input  logic [OWNER_W-1:0] exp_owner,
  output logic               ident_ok
);
  logic addr_ok;
  logic type_ok;
  logic code_known;
  logic owner_ok;

  always_comb begin
    addr_ok    = (ent_lin_addr == acc_addr);
    code_known = (exp_type == PTYPE_THREAD) || (exp_type == PTYPE_REGULAR);
    type_ok    = code_known && (ent_type == exp_type);
  end

  generate
    if (OWNER_CHK_EN) begin : g_owner
      always_comb begin
        owner_ok = (exp_type != PTYPE_REGULAR) || (ent_owner == exp_owner);
      end
    end else begin : g_no_owner
      logic unused_owner;
      always_comb begin
        unused_owner = ^{ent_owner, exp_owner};
        owner_ok     = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    ident_ok = addr_ok & type_ok & owner_ok;
  end
endmodule

// File: rtl/pmc_perm_chk.sv
module pmc_perm_chk
  import pmc_pkg::*;
(
  input  ent_flags_t flags,
  input  logic       need_rw,
  output logic       perm_ok
);
  always_comb begin
    perm_ok = ~need_rw | (flags.rd & flags.wr);
  end
endmodule

// File: rtl/pmc_result_reg.sv
module pmc_result_reg #(
  parameter int unsigned ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              req_valid,
  input  logic              check_ok,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              done,
  output logic              pass,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr
);
  logic              done_d;
  logic              pass_d;
  logic              fault_d;
  logic [ADDR_W-1:0] addr_d;
  logic              res_en;

  always_comb begin
    res_en  = req_valid;
    done_d  = req_valid;
    pass_d  = check_ok;
    fault_d = ~check_ok;
    addr_d  = check_ok ? '0 : acc_addr;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pass       <= 1'b0;
      fault      <= 1'b0;
      fault_addr <= '0;
    end else if (res_en) begin
      pass       <= pass_d;
      fault      <= fault_d;
      fault_addr <= addr_d;
    end
  end
endmodule

// File: rtl/pmc_entry_checker.sv
module pmc_entry_checker
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned OWNER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               ent_valid,
  input  logic               ent_blocked,
  input  logic               ent_pending,
  input  logic               ent_modified,
  input  logic [ADDR_W-1:0]  ent_lin_addr,
  input  logic [2:0]         ent_type,
  input  logic [OWNER_W-1:0] ent_owner,
  input  logic               ent_read,
  input  logic               ent_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [2:0]         exp_type,
  input  logic [OWNER_W-1:0] exp_owner,
  input  logic               need_rw,
  output logic               done,
  output logic               pass,
  output logic               fault,
  output logic [ADDR_W-1:0]  fault_addr
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;
  ent_flags_t             flags;
  logic                   state_ok;
  logic                   ident_ok;
  logic                   perm_ok;
  logic                   check_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  always_comb begin
    rst_q_n        = rst_pipe[SYNC_STAGES-1];
    flags.valid    = ent_valid;
    flags.blocked  = ent_blocked;
    flags.pending  = ent_pending;
    flags.modified = ent_modified;
    flags.rd       = ent_read;
    flags.wr       = ent_write;
    check_ok       = state_ok & ident_ok & perm_ok;
  end

  pmc_state_chk u_state (
    .flags    (flags),
    .state_ok (state_ok)
  );

  pmc_ident_chk #(
    .ADDR_W       (ADDR_W),
    .OWNER_W      (OWNER_W),
    .OWNER_CHK_EN (1'b1)
  ) u_ident (
    .ent_lin_addr (ent_lin_addr),
    .acc_addr     (acc_addr),
    .ent_type     (ent_type),
    .exp_type     (exp_type),
    .ent_owner    (ent_owner),
    .exp_owner    (exp_owner),
    .ident_ok     (ident_ok)
  );

  pmc_perm_chk u_perm (
    .flags   (flags),
    .need_rw (need_rw),
    .perm_ok (perm_ok)
  );

  pmc_result_reg #(
    .ADDR_W (ADDR_W)
  ) u_result (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .req_valid  (req_valid),
    .check_ok   (check_ok),
    .acc_addr   (acc_addr),
    .done       (done),
    .pass       (pass),
    .fault      (fault),
    .fault_addr (fault_addr)
  );
endmodule

// File: rtl/pmc_entry_checker_sva.sv
module pmc_entry_checker_sva #(
  parameter int unsigned ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              req_valid,
  input logic              ent_valid,
  input logic              ent_blocked,
  input logic              ent_pending,
  input logic              ent_modified,
  input logic [ADDR_W-1:0] ent_lin_addr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              done,
  input logic              pass,
  input logic              fault,
  input logic [ADDR_W-1:0] fault_addr
);
  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> done); // R2
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !done); // R2
  AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && !ent_valid) |=> (fault && fault_addr == $past(acc_addr))); // R3
  AST_BLOCKED_FAULTS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && ent_blocked) |=> fault); // R4
  AST_TRANSIT_FAULTS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && (ent_pending || ent_modified)) |=> fault); // R5
  AST_ADDR_MISMATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && ent_lin_addr != acc_addr) |=> fault); // R6
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |-> $onehot({pass, fault})); // R10
  AST_PASS_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && pass) |-> (fault_addr == '0)); // R10
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> ($stable(pass) && $stable(fault) && $stable(fault_addr))); // R11
endmodule

bind pmc_entry_checker pmc_entry_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .req_valid    (req_valid),
  .ent_valid    (ent_valid),
  .ent_blocked  (ent_blocked),
  .ent_pending  (ent_pending),
  .ent_modified (ent_modified),
  .ent_lin_addr (ent_lin_addr),
  .acc_addr     (acc_addr),
  .done         (done),
  .pass         (pass),
  .fault        (fault),
  .fault_addr   (fault_addr)
);

// File: tb/tb_pmc_entry_checker.sv
module tb_pmc_entry_checker;
  localparam int unsigned ADDR_W   = 48;
  localparam int unsigned OWNER_W  = 16;
  localparam time         CLK_PER  = 10ns;
  localparam int          NVEC     = 32768;

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic               ent_valid, ent_blocked, ent_pending, ent_modified;
  logic [ADDR_W-1:0]  ent_lin_addr, acc_addr;
  logic [2:0]         ent_type, exp_type;
  logic [OWNER_W-1:0] ent_owner, exp_owner;
  logic               ent_read, ent_write, need_rw;
  logic               done, pass, fault;
  logic [ADDR_W-1:0]  fault_addr;

  int n_chk;
  int n_bad;

  pmc_entry_checker #(.ADDR_W(ADDR_W), .OWNER_W(OWNER_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .ent_valid(ent_valid), .ent_blocked(ent_blocked),
    .ent_pending(ent_pending), .ent_modified(ent_modified),
    .ent_lin_addr(ent_lin_addr), .ent_type(ent_type), .ent_owner(ent_owner),
    .ent_read(ent_read), .ent_write(ent_write), .acc_addr(acc_addr),
    .exp_type(exp_type), .exp_owner(exp_owner), .need_rw(need_rw),
    .done(done), .pass(pass), .fault(fault), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input logic [ADDR_W+2:0] act,
                       input logic [ADDR_W+2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual done/pass/fault/addr=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble(input int seed);
    ent_valid    = seed[0];
    ent_blocked  = seed[3];
    ent_pending  = seed[5];
    ent_modified = seed[1];
    ent_read     = seed[2];
    ent_write    = seed[4];
    ent_type     = seed[8:6];
    exp_type     = seed[11:9];
    need_rw      = seed[7];
    ent_lin_addr = {ADDR_W{1'b1}} ^ ADDR_W'(seed * 977);
    acc_addr     = ADDR_W'(seed * 31);
    ent_owner    = OWNER_W'(seed);
    exp_owner    = ~OWNER_W'(seed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] held_addr;
    logic              held_pass, held_fault;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    scramble(5);
    repeat (3) @(negedge clk);
    check("R1 in reset", {done, pass, fault, fault_addr}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {done, pass, fault, fault_addr}, '0);

    for (int i = 0; i < NVEC; i++) begin
      logic v, b, p, m, r, w, amatch, omatch, rw, ok;
      logic [2:0] et, xt;
      string why;
      v = i[0]; b = i[1]; p = i[2]; m = i[3]; r = i[4]; w = i[5];
      amatch = i[6]; et = i[9:7]; xt = i[12:10]; omatch = i[13]; rw = i[14];
      @(negedge clk);
      ent_valid = v; ent_blocked = b; ent_pending = p; ent_modified = m;
      ent_read = r; ent_write = w; ent_type = et; exp_type = xt; need_rw = rw;
      acc_addr = ADDR_W'(48'h0000_1000 * (i + 1)) ^ 48'hA5A0_0000_0000;
      ent_lin_addr = amatch ? acc_addr : acc_addr ^ (ADDR_W'(1) << (i % ADDR_W));
      exp_owner = OWNER_W'(i * 7 + 3);
      ent_owner = omatch ? exp_owner : exp_owner ^ (OWNER_W'(1) << (i % OWNER_W));
      req_valid = 1'b1;
      // Expected verdict from R3..R9
      ok = 1'b1; why = "R10 pass";
      if (!v) begin ok = 1'b0; why = "R3 invalid"; end
      else if (b) begin ok = 1'b0; why = "R4 blocked"; end
      else if (p || m) begin ok = 1'b0; why = "R5 transit"; end
      else if (!amatch) begin ok = 1'b0; why = "R6 address"; end
      else if (et != xt || (xt != 3'd1 && xt != 3'd2)) begin ok = 1'b0; why = "R7 type"; end
      else if (xt == 3'd2 && !omatch) begin ok = 1'b0; why = "R8 owner"; end
      else if (rw && !(r && w)) begin ok = 1'b0; why = "R9 perm"; end
      else if (xt == 3'd1 && !omatch) why = "R8 owner ignored";
      else if (!rw && !(r && w)) why = "R9 perm ignored";
      held_addr = ok ? '0 : acc_addr;
      @(negedge clk);
      req_valid = 1'b0;
      check(why, {done, pass, fault, fault_addr}, {1'b1, ok, ~ok, held_addr});
      held_pass = ok; held_fault = ~ok;
      scramble(i * 13 + 1);
      @(negedge clk);
      check("R2 R11 hold", {done, pass, fault, fault_addr},
            {1'b0, held_pass, held_fault, held_addr});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule